// File: doc/BRIEF.md
# Overlay-Aware Line Translation Unit

This block translates cache-line-granular loads and stores in a virtual memory scheme where each virtual page is backed by two things: an ordinary physical page, and a sparse overlay that may hold newer copies of any subset of that page's 64-byte lines. A small fully associative table keeps one entry per cached page. Each entry holds the virtual page number, the physical page number, a copy-on-write flag and a 64-bit overlay vector with one bit per line. For every request the unit returns, one cycle later, either a physical address, an overlay-space address, or a miss indication.

Overlay-space addresses need no extra lookup. They are a direct image of the virtual address placed in an otherwise unused region of the physical map, marked by a reserved top bit. A store to a copy-on-write page does not copy the page. The unit instead moves the one line it touches into the overlay by setting that line's bit. It emits a one-cycle notice carrying the page and line numbers, so that other translation caches can follow the change. A side port loads entries, and an invalidate port drops them.

Top module: `ovl_xlate`

## Requirements
- R1: Each request cycle (`req_valid`=1) produces `rsp_valid`=1 exactly one clock later. A cycle without a request leaves `rsp_valid`, `rsp_miss`, `rsp_overlay`, `rsp_addr` and `upd_valid` at 0 one clock later.
- R2: A request whose virtual page number (`req_vaddr[VA_W-1:12]`) matches no valid entry responds with `rsp_miss`=1, `rsp_overlay`=0, `rsp_addr`=0 and no update pulse.
- R3: A read that hits a line whose overlay bit is clear responds with `rsp_addr` = {1'b0, entry physical page number, `req_vaddr[11:0]`}. The bit index is `req_vaddr[11:6]`.
- R4: A request that hits a line whose overlay bit is set responds with `rsp_overlay`=1 and `rsp_addr` = {1'b1, `req_vaddr`}.
- R5: A write that hits a copy-on-write entry on a line whose bit is clear responds with the overlay address of R4 and sets that bit. In the same cycle as the response it raises `upd_valid` for exactly one cycle, with `upd_vpn` equal to the page and `upd_line` equal to `req_vaddr[11:6]`. Outside such pulses `upd_vpn` and `upd_line` are 0.
- R6: A write to a non-copy-on-write entry on a line whose bit is clear goes to the physical address of R3. It raises no update pulse and leaves the bit clear.
- R7: A write to a line whose bit is already set goes to the overlay address and raises no update pulse.
- R8: A bit set by a write is seen by a request issued in the very next cycle.
- R9: A load (`fill_valid`) whose page number matches a valid entry overwrites that entry's physical page number, copy-on-write flag and bit vector. Otherwise the load takes the lowest-numbered invalid slot. If every slot is valid, it takes the slot named by a round-robin pointer, which starts at 0 after reset and advances by one, wrapping, after each such eviction.
- R10: An invalidate (`inv_valid`) clears the entry whose page number equals `inv_vpn`, so later requests to that page miss. Entries for other pages are unaffected.
- R11: After reset every entry is invalid and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_vaddr | input | VA_W (32) | Virtual byte address |
| fill_valid | input | 1 | Load an entry |
| fill_vpn | input | PN_W (20) | Page number of the entry to load |
| fill_ppn | input | PN_W (20) | Physical page number to load |
| fill_cow | input | 1 | Copy-on-write flag to load |
| fill_bits | input | 64 | Overlay line vector to load |
| inv_valid | input | 1 | Invalidate strobe |
| inv_vpn | input | PN_W (20) | Page number to invalidate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_overlay | output | 1 | Address is in overlay space |
| rsp_addr | output | VA_W+1 (33) | Translated address |
| upd_valid | output | 1 | One-cycle overlay-bit-set notice |
| upd_vpn | output | PN_W (20) | Page whose bit was set |
| upd_line | output | 6 | Line whose bit was set |

## Verification
A corrupted overlay vector or copy-on-write flag shows up at the next access to the affected line: the address lands in the wrong space, or an update notice is missing or repeated. A wrong page number or valid flag gives a wrong physical page or a spurious miss on the first request to that page. A wrong replacement pointer stays hidden until a later eviction removes the wrong page, and only the next miss or stale hit on that page exposes it. For this reason the random phase uses a small page pool that keeps the table full and evicting.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int unsigned LINE_OFF_W = 6;
    localparam int unsigned LINE_IDX_W = 6;
    localparam int unsigned LINES      = 1 << LINE_IDX_W;
    localparam int unsigned PAGE_OFF_W = LINE_OFF_W + LINE_IDX_W;

    typedef logic [LINES-1:0]      line_vec_t;
    typedef logic [LINE_IDX_W-1:0] line_idx_t;
endpackage

// File: rtl/ovl_match.sv
module ovl_match #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned PN_W    = 20,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [ENTRIES-1:0]           valid_i,
    input  logic [ENTRIES-1:0][PN_W-1:0] vpn_i,
    input  logic [PN_W-1:0]              key_i,
    output logic [ENTRIES-1:0]           hit_vec_o,
    output logic                         hit_o,
    output logic [IDX_W-1:0]             idx_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec_o[g] = valid_i[g] && (vpn_i[g] == key_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec_o[i]) idx_o = IDX_W'(i);
        end
        hit_o = |hit_vec_o;
    end
endmodule

// File: rtl/ovl_table.sv
module ovl_table
    import ovl_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned PN_W    = 20,
    parameter int unsigned IDX_W   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         set_en_i,
    input  logic [IDX_W-1:0]             set_idx_i,
    input  line_idx_t                    set_line_i,
    input  logic                         fill_en_i,
    input  logic [PN_W-1:0]              fill_vpn_i,
    input  logic [PN_W-1:0]              fill_ppn_i,
    input  logic                         fill_cow_i,
    input  line_vec_t                    fill_bits_i,
    input  logic                         fill_hit_i,
    input  logic [IDX_W-1:0]             fill_idx_i,
    input  logic [ENTRIES-1:0]           inv_vec_i,
    output logic [ENTRIES-1:0]           valid_o,
    output logic [ENTRIES-1:0]           cow_o,
    output logic [ENTRIES-1:0][PN_W-1:0] vpn_o,
    output logic [ENTRIES-1:0][PN_W-1:0] ppn_o,
    output logic [ENTRIES-1:0][LINES-1:0] bits_o
);
    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0]            cow;
        logic [ENTRIES-1:0][PN_W-1:0]  vpn;
        logic [ENTRIES-1:0][PN_W-1:0]  ppn;
        logic [ENTRIES-1:0][LINES-1:0] bits;
        logic [IDX_W-1:0]              rr;
    } tbl_t;

    tbl_t             st_d, st_q;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] slot;

    always_comb begin
        st_d       = st_q;
        free_found = 1'b0;
        free_idx   = '0;
        slot       = '0;

        if (set_en_i) st_d.bits[set_idx_i][set_line_i] = 1'b1;

        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!st_q.valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end

        if (fill_en_i) begin
            if (fill_hit_i)      slot = fill_idx_i;
            else if (free_found) slot = free_idx;
            else begin
                slot    = st_q.rr;
                st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
            end
            st_d.valid[slot] = 1'b1;
            st_d.vpn[slot]   = fill_vpn_i;
            st_d.ppn[slot]   = fill_ppn_i;
            st_d.cow[slot]   = fill_cow_i;
            st_d.bits[slot]  = fill_bits_i;
        end

        st_d.valid = st_d.valid & ~inv_vec_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign cow_o   = st_q.cow;
    assign vpn_o   = st_q.vpn;
    assign ppn_o   = st_q.ppn;
    assign bits_o  = st_q.bits;
endmodule

// File: rtl/ovl_addr_gen.sv
module ovl_addr_gen
    import ovl_pkg::*;
#(
    parameter int unsigned PN_W = 20,
    parameter int unsigned VA_W = PN_W + PAGE_OFF_W
) (
    input  logic            hit_i,
    input  logic            to_overlay_i,
    input  logic [PN_W-1:0] ppn_i,
    input  logic [VA_W-1:0] vaddr_i,
    output logic [VA_W:0]   addr_o
);
    always_comb begin
        if (!hit_i)            addr_o = '0;
        else if (to_overlay_i) addr_o = {1'b1, vaddr_i};
        else                   addr_o = {1'b0, ppn_i, vaddr_i[PAGE_OFF_W-1:0]};
    end
endmodule

// File: rtl/ovl_xlate.sv
module ovl_xlate
    import ovl_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned PN_W    = 20,
    localparam int unsigned VA_W   = PN_W + PAGE_OFF_W,
    localparam int unsigned OUT_W  = VA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              fill_valid,
    input  logic [PN_W-1:0]   fill_vpn,
    input  logic [PN_W-1:0]   fill_ppn,
    input  logic              fill_cow,
    input  logic [LINES-1:0]  fill_bits,
    input  logic              inv_valid,
    input  logic [PN_W-1:0]   inv_vpn,
    output logic              rsp_valid,
    output logic              rsp_miss,
    output logic              rsp_overlay,
    output logic [OUT_W-1:0]  rsp_addr,
    output logic              upd_valid,
    output logic [PN_W-1:0]   upd_vpn,
    output logic [LINE_IDX_W-1:0] upd_line
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic             rsp_valid;
        logic             rsp_miss;
        logic             rsp_overlay;
        logic [OUT_W-1:0] rsp_addr;
        logic             upd_valid;
        logic [PN_W-1:0]  upd_vpn;
        line_idx_t        upd_line;
    } out_t;

    out_t out_d, out_q;

    logic [ENTRIES-1:0]            t_valid, t_cow;
    logic [ENTRIES-1:0][PN_W-1:0]  t_vpn, t_ppn;
    logic [ENTRIES-1:0][LINES-1:0] t_bits;

    logic [PN_W-1:0]    req_vpn;
    line_idx_t          req_line;
    logic [ENTRIES-1:0] req_vec, fill_vec, inv_vec_raw;
    logic               req_hit, fill_hit, inv_hit;
    logic [IDX_W-1:0]   req_idx, fill_idx, inv_idx;
    logic               line_set, need_set, to_ovl;
    logic [OUT_W-1:0]   addr_w;

    assign req_vpn  = req_vaddr[VA_W-1:PAGE_OFF_W];
    assign req_line = req_vaddr[PAGE_OFF_W-1:LINE_OFF_W];

    ovl_match #(.ENTRIES(ENTRIES), .PN_W(PN_W), .IDX_W(IDX_W)) i_req_match (
        .valid_i(t_valid), .vpn_i(t_vpn), .key_i(req_vpn),
        .hit_vec_o(req_vec), .hit_o(req_hit), .idx_o(req_idx)
    );

    ovl_match #(.ENTRIES(ENTRIES), .PN_W(PN_W), .IDX_W(IDX_W)) i_fill_match (
        .valid_i(t_valid), .vpn_i(t_vpn), .key_i(fill_vpn),
        .hit_vec_o(fill_vec), .hit_o(fill_hit), .idx_o(fill_idx)
    );

    ovl_match #(.ENTRIES(ENTRIES), .PN_W(PN_W), .IDX_W(IDX_W)) i_inv_match (
        .valid_i(t_valid), .vpn_i(t_vpn), .key_i(inv_vpn),
        .hit_vec_o(inv_vec_raw), .hit_o(inv_hit), .idx_o(inv_idx)
    );

    always_comb begin
        line_set = t_bits[req_idx][req_line];
        need_set = req_valid && req_write && req_hit && t_cow[req_idx] && !line_set;
        to_ovl   = line_set || need_set;
    end

    ovl_table #(.ENTRIES(ENTRIES), .PN_W(PN_W), .IDX_W(IDX_W)) i_table (
        .clk(clk), .rst_n(rst_n),
        .set_en_i(need_set), .set_idx_i(req_idx), .set_line_i(req_line),
        .fill_en_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
        .fill_cow_i(fill_cow), .fill_bits_i(fill_bits),
        .fill_hit_i(fill_hit), .fill_idx_i(fill_idx),
        .inv_vec_i(inv_vec_raw & {ENTRIES{inv_valid}}),
        .valid_o(t_valid), .cow_o(t_cow), .vpn_o(t_vpn), .ppn_o(t_ppn), .bits_o(t_bits)
    );

    ovl_addr_gen #(.PN_W(PN_W)) i_addr (
        .hit_i(req_valid && req_hit), .to_overlay_i(to_ovl),
        .ppn_i(t_ppn[req_idx]), .vaddr_i(req_vaddr), .addr_o(addr_w)
    );

    always_comb begin
        out_d             = '0;
        out_d.rsp_valid   = req_valid;
        out_d.rsp_miss    = req_valid && !req_hit;
        out_d.rsp_overlay = req_valid && req_hit && to_ovl;
        out_d.rsp_addr    = addr_w;
        if (need_set) begin
            out_d.upd_valid = 1'b1;
            out_d.upd_vpn   = req_vpn;
            out_d.upd_line  = req_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid   = out_q.rsp_valid;
    assign rsp_miss    = out_q.rsp_miss;
    assign rsp_overlay = out_q.rsp_overlay;
    assign rsp_addr    = out_q.rsp_addr;
    assign upd_valid   = out_q.upd_valid;
    assign upd_vpn     = out_q.upd_vpn;
    assign upd_line    = out_q.upd_line;

    logic unused_ok;
    assign unused_ok = inv_hit ^ (|inv_idx);
endmodule

// File: rtl/ovl_xlate_chk.sv
module ovl_xlate_chk
    import ovl_pkg::*;
#(
    parameter int unsigned PN_W = 20,
    localparam int unsigned VA_W = PN_W + PAGE_OFF_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic [VA_W-1:0]       req_vaddr,
    input logic                  fill_valid,
    input logic                  rsp_valid,
    input logic                  rsp_miss,
    input logic                  rsp_overlay,
    input logic [VA_W:0]         rsp_addr,
    input logic                  upd_valid,
    input logic [PN_W-1:0]       upd_vpn,
    input logic [LINE_IDX_W-1:0] upd_line
);
    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_miss && !rsp_overlay && !upd_valid);

    assert_miss_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> !rsp_overlay && rsp_addr == '0 && !upd_valid);

    assert_ovl_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_overlay |-> rsp_addr == {1'b1, $past(req_vaddr)});

    assert_phys_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss && !rsp_overlay) |->
        (!rsp_addr[VA_W] && rsp_addr[PAGE_OFF_W-1:0] == $past(req_vaddr[PAGE_OFF_W-1:0])));

    assert_upd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> rsp_overlay && $past(req_write) &&
        upd_vpn == rsp_addr[VA_W-1:PAGE_OFF_W] && upd_line == rsp_addr[PAGE_OFF_W-1:LINE_OFF_W]);

    assert_set_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !$past(fill_valid) && req_valid &&
         req_vaddr[VA_W-1:LINE_OFF_W] == {upd_vpn, upd_line}) |=> rsp_overlay && !upd_valid);
endmodule

bind ovl_xlate ovl_xlate_chk #(.PN_W(PN_W)) i_ovl_xlate_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .fill_valid(fill_valid), .rsp_valid(rsp_valid),
    .rsp_miss(rsp_miss), .rsp_overlay(rsp_overlay), .rsp_addr(rsp_addr),
    .upd_valid(upd_valid), .upd_vpn(upd_vpn), .upd_line(upd_line)
);

// File: tb/test_ovl_xlate.sv
`timescale 1ns/1ps
module test_ovl_xlate;
    localparam int E    = 8;
    localparam int PN_W = 20;
    localparam int VA_W = PN_W + 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic fill_valid = 0, fill_cow = 0;
    logic [PN_W-1:0] fill_vpn = '0, fill_ppn = '0;
    logic [63:0] fill_bits = '0;
    logic inv_valid = 0;
    logic [PN_W-1:0] inv_vpn = '0;
    logic rsp_valid, rsp_miss, rsp_overlay, upd_valid;
    logic [VA_W:0] rsp_addr;
    logic [PN_W-1:0] upd_vpn;
    logic [5:0] upd_line;

    always #2.5 clk = ~clk;

    ovl_xlate #(.ENTRIES(E), .PN_W(PN_W)) i_ovl_xlate (.*);

    int checks = 0, fails = 0;
    bit done = 0;

    logic            m_valid [E];
    logic            m_cow   [E];
    logic [PN_W-1:0] m_vpn   [E];
    logic [PN_W-1:0] m_ppn   [E];
    logic [63:0]     m_bits  [E];
    int              m_rr;

    localparam int OW = 1 + 1 + 1 + (VA_W + 1) + 1 + PN_W + 6;

    task automatic check(string tag, logic [OW-1:0] act, logic [OW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] outs();
        return {rsp_valid, rsp_miss, rsp_overlay, rsp_addr, upd_valid, upd_vpn, upd_line};
    endfunction

    function automatic int lookup(logic [PN_W-1:0] v);
        for (int i = 0; i < E; i++) if (m_valid[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    task automatic do_req(bit wr, logic [VA_W-1:0] va, string tag);
        logic [PN_W-1:0] vpn = va[VA_W-1:12];
        logic [5:0] ln = va[11:6];
        int idx = lookup(vpn);
        logic [OW-1:0] exp;
        string t;
        bit bit_set, set_now;
        exp = '0;
        if (idx < 0) begin
            exp = {1'b1, 1'b1, 1'b0, {(VA_W+1){1'b0}}, 1'b0, {PN_W{1'b0}}, 6'd0};
            t = "R2";
        end else begin
            bit_set = m_bits[idx][ln];
            set_now = wr && m_cow[idx] && !bit_set;
            if (bit_set || set_now)
                exp = {1'b1, 1'b0, 1'b1, {1'b1, va}, set_now, set_now ? vpn : {PN_W{1'b0}}, set_now ? ln : 6'd0};
            else
                exp = {1'b1, 1'b0, 1'b0, {1'b0, m_ppn[idx], va[11:0]}, 1'b0, {PN_W{1'b0}}, 6'd0};
            t = set_now ? "R5" : bit_set ? (wr ? "R7" : "R4") : (wr ? "R6" : "R3");
            if (set_now) m_bits[idx][ln] = 1'b1;
        end
        if (tag != "") t = {tag, "/", t};
        req_valid = 1; req_write = wr; req_vaddr = va;
        @(posedge clk); @(negedge clk);
        req_valid = 0; req_write = 0;
        check(t, outs(), exp);
    endtask

    task automatic do_fill(logic [PN_W-1:0] v, logic [PN_W-1:0] p, bit c, logic [63:0] b);
        int idx = lookup(v);
        if (idx < 0) begin
            for (int i = E - 1; i >= 0; i--) if (!m_valid[i]) idx = i;
            if (idx < 0) begin
                idx = m_rr;
                m_rr = (m_rr + 1) % E;
            end
        end
        m_valid[idx] = 1; m_vpn[idx] = v; m_ppn[idx] = p; m_cow[idx] = c; m_bits[idx] = b;
        fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_cow = c; fill_bits = b;
        @(posedge clk); @(negedge clk);
        fill_valid = 0;
        check("R1 idle after fill", outs(), '0);
    endtask

    task automatic do_inv(logic [PN_W-1:0] v);
        int idx = lookup(v);
        if (idx >= 0) m_valid[idx] = 0;
        inv_valid = 1; inv_vpn = v;
        @(posedge clk); @(negedge clk);
        inv_valid = 0;
    endtask

    function automatic logic [VA_W-1:0] va_of(logic [PN_W-1:0] v, int ln, int off);
        return {v, 6'(ln), 6'(off)};
    endfunction

    function automatic logic [PN_W-1:0] pool(int i);
        return PN_W'(20'h3A000 + i * 20'h131);
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < E; i++) begin
            m_valid[i] = 0; m_cow[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_bits[i] = '0;
        end
        m_rr = 0;
        repeat (3) @(negedge clk);
        check("R11 reset outputs", outs(), '0);
        rst_n = 1;
        @(negedge clk);
        check("R11 idle after reset", outs(), '0);
        do_req(0, va_of(pool(0), 3, 5), "R11 empty table");

        do_fill(pool(0), 20'h00111, 0, 64'h8);
        do_req(0, va_of(pool(0), 0, 9), "R3");
        do_req(0, va_of(pool(0), 3, 1), "R4");
        do_req(1, va_of(pool(0), 5, 2), "R6");
        do_req(0, va_of(pool(0), 5, 2), "R6 bit unchanged");

        do_fill(pool(1), 20'h00222, 1, 64'h0);
        do_req(1, va_of(pool(1), 7, 4), "R5");
        do_req(1, va_of(pool(1), 7, 8), "R8 R7");
        do_req(0, va_of(pool(1), 7, 0), "R8");
        do_req(1, va_of(pool(1), 63, 63), "R5 top line");
        do_req(0, va_of(pool(1), 6, 0), "R5 neighbour");

        do_fill(pool(1), 20'h00333, 0, 64'h0);
        do_req(0, va_of(pool(1), 7, 0), "R9 overwrite");
        do_req(1, va_of(pool(1), 8, 0), "R9 cow cleared");

        do_inv(pool(0));
        do_req(0, va_of(pool(0), 0, 0), "R10 dropped");
        do_req(0, va_of(pool(1), 0, 0), "R10 kept");

        for (int i = 2; i < 12; i++) do_fill(pool(i), PN_W'(i * 7 + 1), i[0], 64'h1);
        for (int i = 0; i < 12; i++) do_req(0, va_of(pool(i), 0, 0), "R9 eviction");

        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            logic [PN_W-1:0] v = pool($urandom_range(0, 11));
            if (r < 10)
                do_fill(v, PN_W'($urandom), 1'($urandom),
                        {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            else if (r < 15)
                do_inv(v);
            else if (r < 18)
                do_req(1'($urandom), {PN_W'($urandom) | 20'h80000, 12'($urandom)}, "R2 random");
            else
                do_req(1'($urandom), va_of(v, $urandom_range(0, 63), $urandom_range(0, 63)), "");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule